// File: doc/BRIEF.md
# Cascaded Serial-to-Parallel Lamp Receiver

This block listens to one asynchronous serial line and turns each character it receives into channel outputs, such as lamp drivers. It waits until the line falls from its idle high level. That falling edge marks the start of a character. The block then runs a bit timer derived from the fast system clock and samples eight data bits near their centres. Each sample is pushed directly into the first position of a long shift chain built from 8-bit groups. Every new character moves the older bits one group further along the chain, and bits that leave the last group are lost.

The block has no holding register. The channel outputs therefore ripple while a character arrives and settle once the eighth bit has been taken. Each output is the inverse of the bit stored behind it. The bit rate is chosen by parameters, and both 9600 and 57600 baud from a 50 MHz clock fall well inside the 5% timing tolerance.

Top module: `lamp_shift_rx`

## Requirements
- R1: While reset is asserted, and once it is released, every channel output is high until the first data bit is taken.
- R2: While the line stays high and no character is in progress, the channel outputs do not change.
- R3: The start bit is never stored. The 8 data bits are taken least significant bit first, so after one character `chan_o[7-i]` equals the inverse of data bit i.
- R4: Each stored bit moves one position toward higher channel indices. After a character, the previous contents of `chan_o[CH-9:0]` appear in `chan_o[CH-1:8]`, and the top eight bits are discarded.
- R5: Receiving 0xFF drives the eight outputs of the first group low, and receiving 0x00 drives them high.
- R6: The outputs move one position per sampled bit as the character arrives. Four bit periods after the start bit ends, only the first four data bits have been shifted in.
- R7: Two characters separated by a single stop bit are both received correctly.
- R8: Transitions on the line inside a character do not restart reception. Exactly 8 bits are shifted per character.
- R9: The first sample falls 1.5 bit periods after the start edge is detected. Each following sample falls exactly one bit period (`CLKS_PER_BIT` clocks) after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_i | input | 1 | Serial line, idle high |
| chan_o | output | 8*GROUPS | Inverted channel outputs; bit 0 receives each new bit |

## Verification
Directed characters 0xFF and 0x00 confirm the inversion and a whole-group push. An asymmetric value (0x41) shows whether the bit order is reversed or the start bit was taken in. The alternating values 0x55 and 0xAA, sent back to back with one stop bit, put falling edges inside the data and catch a block that restarts on any edge or loses a character during the short gap. A run of random characters with random one- or two-bit gaps fills the chain past its end, which shows whether old bits are discarded cleanly. A sample of the outputs in the middle of a character, together with long idle stretches and a reset during a character, separates immediate shifting from buffered updates and spurious activity.

// File: rtl/lamp_rx_pkg.sv
package lamp_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } rx_state_t;

  localparam int unsigned GROUP_W = 8;
endpackage

// File: rtl/lamp_rx_sync.sv
module lamp_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rx_s,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rx_s = sync_q;
  assign fall = prev_q & ~sync_q;
endmodule

// File: rtl/lamp_rx_ctrl.sv
module lamp_rx_ctrl
  import lamp_rx_pkg::*;
#(
  parameter int unsigned CLKS_PER_BIT = 868
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  output logic shift_en,
  output logic busy
);
  localparam int unsigned FIRST_LD = CLKS_PER_BIT + CLKS_PER_BIT / 2 - 1;
  localparam int unsigned FULL_LD  = CLKS_PER_BIT - 1;
  localparam int unsigned TW       = $clog2(FIRST_LD + 1);

  rx_state_t       state_q, state_d;
  logic [TW-1:0]   tmr_q, tmr_d;
  logic [2:0]      cnt_q, cnt_d;
  logic            tick;

  assign tick = (state_q != ST_IDLE) && (tmr_q == '0);

  always_comb begin
    state_d  = state_q;
    tmr_d    = tmr_q;
    cnt_d    = cnt_q;
    shift_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (fall) begin
          state_d = ST_RUN;
          tmr_d   = TW'(FIRST_LD);
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (tick) begin
          shift_en = 1'b1;
          tmr_d    = TW'(FULL_LD);
          cnt_d    = cnt_q + 3'd1;
          if (cnt_q == 3'd7) state_d = ST_HOLD;
        end else begin
          tmr_d = tmr_q - TW'(1);
        end
      end
      ST_HOLD: begin
        if (tick) state_d = ST_IDLE;
        else      tmr_d   = tmr_q - TW'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy = (state_q == ST_RUN);
endmodule

// File: rtl/lamp_rx_chain.sv
module lamp_rx_chain
  import lamp_rx_pkg::*;
#(
  parameter int unsigned GROUPS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        din,
  output logic [GROUPS*GROUP_W-1:0]   q
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [GROUP_W-1:0] grp_q;
    logic               sin;

    if (g == 0) begin : g_head
      assign sin = din;
    end else begin : g_link
      assign sin = q[g*GROUP_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  grp_q <= '0;
      else if (en) grp_q <= {grp_q[GROUP_W-2:0], sin};
    end

    assign q[g*GROUP_W +: GROUP_W] = grp_q;
  end
endmodule

// File: rtl/lamp_shift_rx.sv
module lamp_shift_rx
  import lamp_rx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned BAUD   = 57_600,
  parameter int unsigned GROUPS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_i,
  output logic [GROUPS*8-1:0]       chan_o
);
  localparam int unsigned CLKS_PER_BIT = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int unsigned CH           = GROUPS * GROUP_W;

  logic          rst_m_q, rst_s_q;
  logic          rx_s, fall, shift_en, busy;
  logic [CH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  lamp_rx_sync u_sync (
    .clk  (clk),
    .rst_n(rst_s_q),
    .rx_i (rx_i),
    .rx_s (rx_s),
    .fall (fall)
  );

  lamp_rx_ctrl #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .fall    (fall),
    .shift_en(shift_en),
    .busy    (busy)
  );

  lamp_rx_chain #(.GROUPS(GROUPS)) u_chain (
    .clk  (clk),
    .rst_n(rst_s_q),
    .en   (shift_en),
    .din  (rx_s),
    .q    (chain_q)
  );

  assign chan_o = ~chain_q;
endmodule

// File: rtl/lamp_shift_rx_chk.sv
module lamp_shift_rx_chk #(
  parameter int unsigned CH  = 32,
  parameter int unsigned CPB = 868
) (
  input logic          clk,
  input logic          rst_n,
  input logic          shift_en,
  input logic          busy,
  input logic          rx_s,
  input logic [CH-1:0] chan_o
);
  localparam int unsigned GW = $clog2(CPB + 2);

  logic [GW-1:0] gap_q;
  logic [3:0]    nshift_q;
  logic          busy_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q    <= '0;
      nshift_q <= '0;
      busy_d   <= 1'b0;
    end else begin
      busy_d <= busy;
      if (shift_en)                  gap_q <= GW'(1);
      else if (gap_q != GW'(CPB + 1)) gap_q <= gap_q + GW'(1);
      if (busy && !busy_d)  nshift_q <= shift_en ? 4'd1 : 4'd0;
      else if (shift_en)    nshift_q <= nshift_q + 4'd1;
    end
  end

  assert_reset_high_R1: assert property (@(posedge clk)
    !rst_n |=> (chan_o == '1));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(chan_o));

  assert_new_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> chan_o[0] == !$past(rx_s));

  assert_move_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> chan_o[CH-1:1] == $past(chan_o[CH-2:0]));

  assert_eight_shifts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_d && !busy) |-> nshift_q == 4'd8);

  assert_bit_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && busy && nshift_q != 4'd0 && busy_d) |-> gap_q == GW'(CPB));
endmodule

bind lamp_shift_rx lamp_shift_rx_chk #(.CH(CH), .CPB(CLKS_PER_BIT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .shift_en(shift_en),
  .busy    (busy),
  .rx_s    (rx_s),
  .chan_o  (chan_o)
);

// File: tb/lamp_shift_rx_bench.sv
module lamp_shift_rx_bench;
  localparam int unsigned CLK_HZ = 50_000_000;
  localparam int unsigned BAUD   = 57_600;
  localparam int unsigned GROUPS = 4;
  localparam int unsigned CH     = GROUPS * 8;
  localparam int unsigned T      = (CLK_HZ + BAUD / 2) / BAUD;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_i = 1'b1;
  logic [CH-1:0] chan_o;
  logic [CH-1:0] model_q;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  lamp_shift_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .GROUPS(GROUPS)) u_lamp_shift_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .rx_i  (rx_i),
    .chan_o(chan_o)
  );

  function automatic logic [CH-1:0] push_bit(logic [CH-1:0] q, logic b);
    return {q[CH-2:0], b};
  endfunction

  task automatic check(string tag, logic [CH-1:0] act, logic [CH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_bits(int n);
    repeat (n * T) @(negedge clk);
  endtask

  task automatic send(logic [7:0] b, int stops, bit mid_chk);
    rx_i = 1'b0;
    wait_bits(1);
    for (int i = 0; i < 8; i++) begin
      if (mid_chk && i == 4)
        check("R6 mid-character shift", chan_o, ~model_q);
      rx_i = b[i];
      wait_bits(1);
      model_q = push_bit(model_q, b[i]);
    end
    rx_i = 1'b1;
    wait_bits(stops);
  endtask

  initial begin
    repeat (195_000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    int         st;
    model_q = '0;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    check("R1 outputs high in reset", chan_o, '1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 outputs high after release", chan_o, '1);

    wait_bits(3);
    check("R2 idle line leaves outputs", chan_o, ~model_q);

    send(8'hFF, 2, 1'b0);
    check("R5 0xFF drives group low", {24'h0, chan_o[7:0]}, 32'h0);
    send(8'h00, 2, 1'b0);
    check("R5 0x00 drives group high", {24'h0, chan_o[7:0]}, 32'hFF);
    check("R4 previous group moved on", chan_o, ~model_q);

    send(8'h41, 2, 1'b1);
    check("R3 bit order 0x41", chan_o, ~model_q);

    send(8'h55, 1, 1'b0);
    send(8'hAA, 1, 1'b0);
    check("R7 R8 back-to-back one stop bit", chan_o, ~model_q);

    for (int k = 0; k < 8; k++) begin
      rb = 8'($urandom_range(255, 0));
      st = int'($urandom_range(2, 1));
      send(rb, st, k == 2);
      check("R3 R4 random character", chan_o, ~model_q);
    end

    wait_bits(2);
    check("R2 idle after traffic", chan_o, ~model_q);

    rx_i = 1'b0;
    wait_bits(1);
    rx_i = 1'b1;
    wait_bits(2);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_q = '0;
    check("R1 reset during character", chan_o, '1);
    rst_n = 1'b1;
    wait_bits(7);
    check("R1 R2 quiet after reset", chan_o, '1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule